// File: doc/BRIEF.md
# Idempotent Check Event Filter

The filter sits in the path of a stream of monitoring events that an application core sends to a software monitor. It removes check events whose outcome is already known: a load or store check to an address whose check was recently forwarded, with no event since then that could have changed the metadata behind that address. Every other event passes through one cycle later, unchanged.

Past check events are held in a small set-associative table, four ways by default. Each entry holds an address tag and one seen bit each for loads and for stores. Two monitor policies are selected by a configuration bit. In allocation-checking mode, a single check covers both loads and stores to an address until a free event. In race-detection mode, the first load and the first store to an address are each forwarded once between synchronisation events. The events that clear the filter depend on the mode and are always forwarded. A bypass bit turns filtering off completely.

Top module: `ief_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low. After reset the table is empty, so the first check to any address is forwarded.
- R2: The event accepted at a clock edge (`in_valid` high) is presented, if forwarded, on `out_valid`/`out_kind`/`out_addr` after that same edge, with its kind and address unchanged. Events that are not checks are always forwarded. Kind codes are: 0 load, 1 store, 2 free, 3 lock, 4 unlock.
- R3: In allocation-checking mode (`cfg_mode`=0), the first load or store to an address is forwarded. Any later load or store to that address is dropped.
- R4: In allocation-checking mode, a free event clears the whole table in one cycle, so the next check to any address is forwarded. Lock and unlock events are forwarded and leave the table as it was.
- R5: In race-detection mode (`cfg_mode`=1), the first load and the first store to an address are each forwarded once. Repeated loads and repeated stores to it are dropped.
- R6: In race-detection mode, a lock or an unlock clears the whole table. A free is forwarded and leaves the table as it was.
- R7: The set is selected by the low `SET_BITS` address bits (2 by default). Each set holds `WAYS` entries (4 by default). A miss fills an empty way if one exists, otherwise the least recently used way. A dropped hit counts as a use.
- R8: With `cfg_bypass`=1, every event is forwarded and the table is neither read for dropping nor modified.
- R9: A cycle with `in_valid` low gives `out_valid` low after that edge and leaves the table unchanged, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | Monitor policy: 0 allocation checking, 1 race detection |
| cfg_bypass | input | 1 | Forward every event, table untouched |
| in_valid | input | 1 | Event present this cycle |
| in_kind | input | 3 | Event kind code |
| in_addr | input | AW | Event address |
| out_valid | output | 1 | Forwarded event present |
| out_kind | output | 3 | Forwarded event kind |
| out_addr | output | AW | Forwarded event address |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the event. The forward-or-drop decision and the copied kind and address appear after that edge. Changes to the table (an install, a seen bit, a clear or an LRU update) affect the very next event. The bench drives each event at a falling edge and samples the outputs one nanosecond after the following rising edge. It then lowers `in_valid`, so every later event sees the table state left by the one before. Replacement and clearing are checked only through the forward or drop decision on later events.

// File: rtl/ief_pkg.sv
package ief_pkg;
  typedef enum logic [2:0] {
    EV_LOAD   = 3'd0,
    EV_STORE  = 3'd1,
    EV_FREE   = 3'd2,
    EV_LOCK   = 3'd3,
    EV_UNLOCK = 3'd4
  } ev_kind_e;

  localparam logic MODE_ALLOC = 1'b0;
  localparam logic MODE_RACE  = 1'b1;
endpackage

// File: rtl/ief_way_match.sv
module ief_way_match #(
  parameter int WAYS = 4,
  parameter int TAGW = 14,
  localparam int RW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]           valid,
  input  logic [WAYS-1:0][TAGW-1:0] tags,
  input  logic [TAGW-1:0]           tag,
  output logic                      hit,
  output logic [RW-1:0]             hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = RW'(w);
    end
  end
endmodule

// File: rtl/ief_victim_sel.sv
module ief_victim_sel #(
  parameter int WAYS = 4,
  localparam int RW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]         valid,
  input  logic [WAYS-1:0][RW-1:0] rank,
  output logic [RW-1:0]           victim
);
  logic found_empty;

  always_comb begin
    victim      = '0;
    found_empty = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (rank[w] == RW'(WAYS-1)) victim = RW'(w);
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!valid[w] && !found_empty) begin
        victim      = RW'(w);
        found_empty = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ief_filter.sv
module ief_filter #(
  parameter int AW       = 16,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_mode,
  input  logic          cfg_bypass,
  input  logic          in_valid,
  input  logic [2:0]    in_kind,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  output logic [2:0]    out_kind,
  output logic [AW-1:0] out_addr
);
  import ief_pkg::*;

  localparam int SETS = 1 << SET_BITS;
  localparam int TAGW = AW - SET_BITS;
  localparam int RW   = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0]           v_q, v_d, ld_q, ld_d, st_q, st_d;
  logic [SETS-1:0][WAYS-1:0][TAGW-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0][RW-1:0]   rank_q, rank_d;
  logic                                out_valid_q, fwd;
  logic [2:0]                          out_kind_q;
  logic [AW-1:0]                       out_addr_q;

  logic [SET_BITS-1:0] idx;
  logic [TAGW-1:0]     tg;
  logic                hit, is_load, is_store, is_check, is_inval, act, drop;
  logic [RW-1:0]       hit_way, victim, touch;
  logic [RW-1:0]       touch_rank;

  assign idx      = in_addr[SET_BITS-1:0];
  assign tg       = in_addr[AW-1:SET_BITS];
  assign is_load  = (in_kind == EV_LOAD);
  assign is_store = (in_kind == EV_STORE);
  assign is_check = is_load || is_store;
  assign is_inval = (cfg_mode == MODE_RACE) ?
                    ((in_kind == EV_LOCK) || (in_kind == EV_UNLOCK)) :
                    (in_kind == EV_FREE);
  assign act      = in_valid && !cfg_bypass;

  ief_way_match #(.WAYS(WAYS), .TAGW(TAGW)) u_match (
    .valid   (v_q[idx]),
    .tags    (tag_q[idx]),
    .tag     (tg),
    .hit     (hit),
    .hit_way (hit_way)
  );

  ief_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid  (v_q[idx]),
    .rank   (rank_q[idx]),
    .victim (victim)
  );

  // next-state logic
  always_comb begin
    v_d    = v_q;
    ld_d   = ld_q;
    st_d   = st_q;
    tag_d  = tag_q;
    rank_d = rank_q;
    drop   = 1'b0;
    touch  = hit ? hit_way : victim;
    touch_rank = rank_q[idx][touch];
    if (act && is_inval) begin
      v_d  = '0;
      ld_d = '0;
      st_d = '0;
    end else if (act && is_check) begin
      if (hit) begin
        if (cfg_mode == MODE_ALLOC) drop = 1'b1;
        else drop = is_load ? ld_q[idx][hit_way] : st_q[idx][hit_way];
        if (is_load)  ld_d[idx][hit_way] = 1'b1;
        if (is_store) st_d[idx][hit_way] = 1'b1;
      end else begin
        v_d[idx][victim]   = 1'b1;
        tag_d[idx][victim] = tg;
        ld_d[idx][victim]  = is_load;
        st_d[idx][victim]  = is_store;
      end
      for (int w = 0; w < WAYS; w++) begin
        if (RW'(w) == touch) rank_d[idx][w] = '0;
        else if (rank_q[idx][w] < touch_rank)
          rank_d[idx][w] = rank_q[idx][w] + RW'(1);
      end
    end
    fwd = in_valid && !drop;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      ld_q <= '0;
      st_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= RW'(w);
    end else begin
      v_q    <= v_d;
      ld_q   <= ld_d;
      st_q   <= st_d;
      rank_q <= rank_d;
    end
  end

  always_ff @(posedge clk) begin
    tag_q <= tag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_kind_q  <= '0;
      out_addr_q  <= '0;
    end else begin
      out_valid_q <= fwd;
      if (in_valid) begin
        out_kind_q <= in_kind;
        out_addr_q <= in_addr;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_kind  = out_kind_q;
  assign out_addr  = out_addr_q;
endmodule

// File: rtl/ief_filter_chk.sv
module ief_filter_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_mode,
  input logic          cfg_bypass,
  input logic          in_valid,
  input logic [2:0]    in_kind,
  input logic [AW-1:0] in_addr,
  input logic          out_valid,
  input logic [2:0]    out_kind,
  input logic [AW-1:0] out_addr
);
  logic in_check;
  assign in_check = in_valid && (in_kind <= 3'd1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind >= 3'd2) |=>
      (out_valid && out_kind == $past(in_kind) && out_addr == $past(in_addr)));

  // R8
  bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_bypass) |=>
      (out_valid && out_addr == $past(in_addr)));

  // R3
  alloc_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && !cfg_bypass && !cfg_mode &&
     $past(in_check) && !$past(cfg_bypass) && !$past(cfg_mode) &&
     $past(in_addr) == in_addr) |=> !out_valid);

  // R5
  race_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && !cfg_bypass && cfg_mode &&
     $past(in_check) && !$past(cfg_bypass) && $past(cfg_mode) &&
     $past(in_addr) == in_addr && $past(in_kind) == in_kind) |=> !out_valid);
endmodule

bind ief_filter ief_filter_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .cfg_bypass (cfg_bypass),
  .in_valid   (in_valid),
  .in_kind    (in_kind),
  .in_addr    (in_addr),
  .out_valid  (out_valid),
  .out_kind   (out_kind),
  .out_addr   (out_addr)
);

// File: tb/ief_filter_tb.sv
`timescale 1ns/1ps
module ief_filter_tb;
  localparam int AW = 16;
  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_FREE = 3'd2,
                         K_LOCK = 3'd3, K_UNLOCK = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_mode, cfg_bypass, in_valid;
  logic [2:0]    in_kind;
  logic [AW-1:0] in_addr;
  logic          out_valid;
  logic [2:0]    out_kind;
  logic [AW-1:0] out_addr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ief_filter #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_kind(in_kind), .in_addr(in_addr),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one event, sampled 1 ns after the accepting edge
  task automatic ev(input logic [2:0] k, input logic [AW-1:0] a,
                    input bit exp_fwd, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_kind  = k;
    in_addr  = a;
    @(posedge clk);
    #1;
    chk(out_valid == exp_fwd, {req, " out_valid"}, int'(out_valid), int'(exp_fwd));
    if (exp_fwd && out_valid) begin
      chk(out_kind == k, {req, " out_kind"}, int'(out_kind), int'(k));
      chk(out_addr == a, {req, " out_addr"}, int'(out_addr), int'(a));
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    in_valid = 1'b0; in_kind = '0; in_addr = '0;
    cfg_mode = 1'b0; cfg_bypass = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 chk(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);
    ev(K_LD, 16'h0010, 1'b1, "R1 empty table");
  endtask

  task automatic t_alloc;
    cfg_mode = 1'b0;
    ev(K_LD,   16'h0010, 1'b0, "R3 repeat load");
    ev(K_ST,   16'h0010, 1'b0, "R3 store after load");
    ev(K_ST,   16'h0020, 1'b1, "R3 new address");
    ev(K_LOCK, 16'h0000, 1'b1, "R4 lock forwarded");
    ev(K_UNLOCK, 16'h0000, 1'b1, "R4 unlock forwarded");
    ev(K_LD,   16'h0010, 1'b0, "R4 lock keeps table");
    ev(K_FREE, 16'h0abc, 1'b1, "R2 free forwarded");
    ev(K_LD,   16'h0010, 1'b1, "R4 after free");
    ev(K_ST,   16'h0020, 1'b1, "R4 after free other");
  endtask

  task automatic t_race;
    cfg_mode = 1'b1;
    ev(K_UNLOCK, 16'h0000, 1'b1, "R6 unlock forwarded");
    ev(K_LD,   16'h0030, 1'b1, "R5 first load");
    ev(K_LD,   16'h0030, 1'b0, "R5 repeat load");
    ev(K_ST,   16'h0030, 1'b1, "R5 first store");
    ev(K_ST,   16'h0030, 1'b0, "R5 repeat store");
    ev(K_FREE, 16'h0030, 1'b1, "R6 free forwarded");
    ev(K_LD,   16'h0030, 1'b0, "R6 free keeps table");
    ev(K_LOCK, 16'h0000, 1'b1, "R6 lock forwarded");
    ev(K_ST,   16'h0030, 1'b1, "R6 store after lock");
    ev(K_LD,   16'h0030, 1'b1, "R6 load after lock");
  endtask

  task automatic t_lru;
    cfg_mode = 1'b0;
    ev(K_FREE, 16'h0000, 1'b1, "R7 clear");
    for (int i = 1; i <= 4; i++)
      ev(K_LD, AW'((i << 8) | 1), 1'b1, "R7 fill set");
    ev(K_LD, 16'h0101, 1'b0, "R7 touch oldest");
    ev(K_LD, 16'h0501, 1'b1, "R7 fifth line");
    ev(K_LD, 16'h0101, 1'b0, "R7 touched line kept");
    ev(K_LD, 16'h0201, 1'b1, "R7 lru line evicted");
    ev(K_LD, 16'h0401, 1'b0, "R7 line kept");
    ev(K_LD, 16'h0102, 1'b1, "R7 other set");
  endtask

  task automatic t_bypass;
    cfg_mode = 1'b0;
    ev(K_LD, 16'h0040, 1'b1, "R8 record");
    cfg_bypass = 1'b1;
    ev(K_LD,   16'h0040, 1'b1, "R8 bypass repeat");
    ev(K_FREE, 16'h0000, 1'b1, "R8 bypass free");
    ev(K_ST,   16'h0050, 1'b1, "R8 bypass new");
    cfg_bypass = 1'b0;
    ev(K_LD, 16'h0040, 1'b0, "R8 table untouched by free");
    ev(K_LD, 16'h0050, 1'b1, "R8 table untouched by check");
  endtask

  task automatic t_idle;
    @(negedge clk);
    in_valid = 1'b0; in_kind = K_FREE; in_addr = 16'h0040;
    @(posedge clk);
    #1 chk(out_valid == 1'b0, "R9 idle", int'(out_valid), 0);
    ev(K_LD, 16'h0040, 1'b0, "R9 idle keeps table");
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_race();
    t_lru();
    t_bypass();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule